// File: doc/BRIEF.md
# Indirect-Indexed Interrupt Routing Register Window

This block is the register front end of an interrupt router. Software sees only two 32-bit locations. One holds an 8-bit select value. The other is a data window: reads and writes made through it reach whichever internal register the select value names. Behind the window are an 8-bit identifier, a read-only version word, a reserved word, and a table of redirection entries. Each entry is 64 bits wide and is reached as two 32-bit halves.

The whole redirection table is driven out in parallel to the interrupt dispatch logic. Every write to an entry half raises a single-cycle rescan strobe, which tells the dispatcher to re-evaluate pending requests against the new settings. The bus is a single-cycle request interface: valid, write enable, address and write data. Read data is registered and appears one cycle after the read request, together with a read-valid flag.

Top module: `irq_route_regwin`

## Requirements
- R1: After reset the select value is 0, the identifier is 0, `rescan` is low, and every entry of `route_table` equals 0x0000_0000_0001_0000 (only bit 16, the mask bit, set).
- R2: A write at offset 0x00 stores `bus_wdata[7:0]` as the select value. A read at offset 0x00 returns the select value zero-extended to 32 bits.
- R3: Only `bus_addr[7:0]` is decoded, so higher address bits have no effect. Offsets other than 0x00 and 0x10 read zero, and writes to them change no state.
- R4: Through the window, select 0x00 reads the identifier in bits 31:24 with bits 23:0 zero. A write there stores only `bus_wdata[31:24]`.
- R5: Through the window, select 0x01 reads 0x0017_0011: version 0x11 in bits 7:0 and the highest entry number (NUM_ENTRIES-1 = 23) in bits 23:16. Writes to it are ignored.
- R6: Through the window, select 0x02 and selects 0x03 to 0x0F read zero, and writes to them are ignored.
- R7: A select s from 0x10 upward addresses entry n = (s-0x10)/2. An even s reaches bits 31:0 and an odd s reaches bits 63:32. Entry n appears on `route_table[64n+63:64n]`, updated in the cycle after the write.
- R8: A write to one half of an entry leaves the other half of that entry, and all other entries, unchanged.
- R9: Selects that name an entry number of 24 or more (0x40 to 0xFF) read zero. Writes to them change no entry and raise no strobe.
- R10: Each window write that reaches an entry half makes `rescan` high for exactly the following cycle. No other access raises it.
- R11: `bus_rvalid` is high exactly in the cycle after a read request, and `bus_rdata` carries the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request valid for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address; only bits 7:0 decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| route_table | output | 64*NUM_ENTRIES (1536) | All redirection entries, entry n at bits 64n+63:64n |
| rescan | output | 1 | One-cycle strobe after each entry-half write |

## Verification
The window is exercised with select values from each class: the identifier, the version word, the reserved and unused low indexes, even and odd entry halves at the first, a middle and the last entry, and indexes past the table. Together these separate a wrong index-to-entry mapping, a swapped half, and a decode that lets out-of-range selects alias onto real entries. Writes of all-ones patterns to the read-only and ignored slots show whether a stray write leaks into the identifier, the version or the table. Accesses at an unused offset, and at the window with high address bits set, show whether the offset decode is exact and limited to the low byte. Low and high writes to the same entry, each compared with the whole parallel table, tell a clean half-merge apart from a clobbered neighbour half.

// File: rtl/irw_pkg.sv
package irw_pkg;

    localparam logic [7:0] SEL_OFFSET    = 8'h00;
    localparam logic [7:0] WINDOW_OFFSET = 8'h10;

    localparam logic [7:0] IDX_IDENT     = 8'h00;
    localparam logic [7:0] IDX_VERSION   = 8'h01;
    localparam logic [7:0] IDX_ENTRY0    = 8'h10;

    localparam logic [7:0] VERSION_CODE  = 8'h11;
    localparam int         MASK_BIT      = 16;

    typedef enum logic [1:0] {
        WIN_ZERO  = 2'd0,
        WIN_IDENT = 2'd1,
        WIN_VER   = 2'd2,
        WIN_ENTRY = 2'd3
    } win_kind_e;

endpackage

// File: rtl/irw_win_decode.sv
module irw_win_decode
    import irw_pkg::*;
#(
    parameter int NUM_ENTRIES = 24,
    parameter int IDX_W       = 5
) (
    input  logic [7:0]       sel_i,
    output win_kind_e        kind_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             hi_o
);

    logic [7:0] rel;
    logic [6:0] num;

    always_comb begin
        rel    = sel_i - IDX_ENTRY0;
        num    = rel[7:1];
        hi_o   = rel[0];
        idx_o  = num[IDX_W-1:0];
        kind_o = WIN_ZERO;
        if (sel_i == IDX_IDENT) begin
            kind_o = WIN_IDENT;
        end else if (sel_i == IDX_VERSION) begin
            kind_o = WIN_VER;
        end else if (sel_i >= IDX_ENTRY0 && int'(num) < NUM_ENTRIES) begin
            kind_o = WIN_ENTRY;
        end
    end

endmodule

// File: rtl/irw_entry_table.sv
module irw_entry_table
    import irw_pkg::*;
#(
    parameter int NUM_ENTRIES = 24,
    parameter int IDX_W       = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic                      wr_hi,
    input  logic [31:0]               wr_data,
    input  logic [IDX_W-1:0]          rd_idx,
    input  logic                      rd_hi,
    output logic [31:0]               rd_data,
    output logic [NUM_ENTRIES*64-1:0] table_o,
    output logic                      rescan_o
);

    localparam logic [63:0] ENTRY_RESET = 64'(1) << MASK_BIT;

    typedef struct packed {
        logic [NUM_ENTRIES-1:0][63:0] ent;
        logic                         rescan;
    } tbl_state_t;

    tbl_state_t state_d, state_q;

    always_comb begin
        state_d        = state_q;
        state_d.rescan = wr_en;
        if (wr_en) begin
            if (wr_hi) begin
                state_d.ent[wr_idx][63:32] = wr_data;
            end else begin
                state_d.ent[wr_idx][31:0]  = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.rescan <= 1'b0;
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                state_q.ent[i] <= ENTRY_RESET;
            end
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data  = rd_hi ? state_q.ent[rd_idx][63:32] : state_q.ent[rd_idx][31:0];
    assign table_o  = state_q.ent;
    assign rescan_o = state_q.rescan;

    // R8: a half write leaves the opposite half of that entry alone
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_half_chk
        assert_other_half_R8 : assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(wr_idx) == g) |=>
                (wr_hi ? $stable(state_q.ent[g][31:0]) : $stable(state_q.ent[g][63:32])));
    end

    // R9: without an entry write the table holds its value
    assert_no_write_stable_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(state_q.ent));

endmodule

// File: rtl/irq_route_regwin.sv
module irq_route_regwin
    import irw_pkg::*;
#(
    parameter int NUM_ENTRIES = 24,
    parameter int ADDR_W      = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_valid,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      bus_rvalid,
    output logic [NUM_ENTRIES*64-1:0] route_table,
    output logic                      rescan
);

    localparam int         IDX_W     = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [7:0] LAST_NUM  = 8'(NUM_ENTRIES - 1);
    localparam logic [31:0] VER_WORD = {8'h00, LAST_NUM, 8'h00, VERSION_CODE};
    localparam logic [7:0] SEL_LIMIT = 8'(16 + 2 * NUM_ENTRIES);

    typedef struct packed {
        logic [7:0]  sel;
        logic [7:0]  ident;
        logic [31:0] rdata;
        logic        rvalid;
    } top_state_t;

    top_state_t state_d, state_q;

    logic [7:0]       offs;
    logic             hit_sel, hit_win;
    win_kind_e        kind;
    logic [IDX_W-1:0] ent_idx;
    logic             ent_hi;
    logic             tbl_wr;
    logic [31:0]      tbl_rd;
    logic             unused_addr_hi;

    assign offs           = bus_addr[7:0];
    assign unused_addr_hi = ^bus_addr[ADDR_W-1:8];
    assign hit_sel        = (offs == SEL_OFFSET);
    assign hit_win        = (offs == WINDOW_OFFSET);

    irw_win_decode #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_decode (
        .sel_i  (state_q.sel),
        .kind_o (kind),
        .idx_o  (ent_idx),
        .hi_o   (ent_hi)
    );

    assign tbl_wr = bus_valid && bus_we && hit_win && (kind == WIN_ENTRY);

    irw_entry_table #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr),
        .wr_idx   (ent_idx),
        .wr_hi    (ent_hi),
        .wr_data  (bus_wdata),
        .rd_idx   (ent_idx),
        .rd_hi    (ent_hi),
        .rd_data  (tbl_rd),
        .table_o  (route_table),
        .rescan_o (rescan)
    );

    always_comb begin
        state_d        = state_q;
        state_d.rvalid = bus_valid && !bus_we;
        state_d.rdata  = '0;
        if (bus_valid && !bus_we) begin
            if (hit_sel) begin
                state_d.rdata = {24'h0, state_q.sel};
            end else if (hit_win) begin
                unique case (kind)
                    WIN_IDENT: state_d.rdata = {state_q.ident, 24'h0};
                    WIN_VER:   state_d.rdata = VER_WORD;
                    WIN_ENTRY: state_d.rdata = tbl_rd;
                    default:   state_d.rdata = '0;
                endcase
            end
        end
        if (bus_valid && bus_we) begin
            if (hit_sel) begin
                state_d.sel = bus_wdata[7:0];
            end else if (hit_win && kind == WIN_IDENT) begin
                state_d.ident = bus_wdata[31:24];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata  = state_q.rdata;
    assign bus_rvalid = state_q.rvalid;

    // R11: read data valid only after a read request
    assert_read_latency_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_valid && !bus_we));

    // R5: version word is constant
    assert_version_word_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we && offs == WINDOW_OFFSET && state_q.sel == IDX_VERSION)
            |=> (bus_rdata == VER_WORD));

    // R4: identifier reads leave the low 24 bits clear
    assert_ident_low_zero_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we && offs == WINDOW_OFFSET && state_q.sel == IDX_IDENT)
            |=> (bus_rdata[23:0] == 24'h0));

    // R10: a strobe is always caused by a window write to an in-range entry index
    assert_rescan_cause_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        rescan |-> $past(bus_valid && bus_we && offs == WINDOW_OFFSET &&
                         state_q.sel >= IDX_ENTRY0 && state_q.sel < SEL_LIMIT));

endmodule

// File: tb/irq_route_regwin_bench.sv
`timescale 1ns/1ps
module irq_route_regwin_bench;

    localparam int N  = 24;
    localparam int AW = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_we = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [N*64-1:0]   route_table;
    logic              rescan;

    int checks = 0;
    int fails  = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    logic [7:0]  m_sel;
    logic [7:0]  m_id;
    logic [63:0] m_ent [N];

    always #10 clk = ~clk;

    irq_route_regwin #(.NUM_ENTRIES(N), .ADDR_W(AW)) u_irq_route_regwin (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .route_table(route_table), .rescan(rescan)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        logic [7:0] o = a[7:0];
        int n;
        if (o == 8'h00) return {24'h0, m_sel};
        if (o != 8'h10) return 32'h0;
        if (m_sel == 8'h00) return {m_id, 24'h0};
        if (m_sel == 8'h01) return 32'h0017_0011;
        if (m_sel < 8'h10) return 32'h0;
        n = (int'(m_sel) - 16) / 2;
        if (n >= N) return 32'h0;
        return m_sel[0] ? m_ent[n][63:32] : m_ent[n][31:0];
    endfunction

    function automatic logic model_write(input logic [AW-1:0] a, input logic [31:0] d);
        logic [7:0] o = a[7:0];
        int n;
        if (o == 8'h00) begin m_sel = d[7:0]; return 1'b0; end
        if (o != 8'h10) return 1'b0;
        if (m_sel == 8'h00) begin m_id = d[31:24]; return 1'b0; end
        if (m_sel < 8'h10) return 1'b0;
        n = (int'(m_sel) - 16) / 2;
        if (n >= N) return 1'b0;
        if (m_sel[0]) m_ent[n][63:32] = d; else m_ent[n][31:0] = d;
        return 1'b1;
    endfunction

    task automatic check_table(input string tag);
        for (int i = 0; i < N; i++) begin
            if (route_table[i*64 +: 64] !== m_ent[i]) begin
                check($sformatf("%s entry %0d", tag, i), route_table[i*64 +: 64], m_ent[i]);
            end
        end
        checks++;
    endtask

    // driver: read pushes its expected value to the scoreboard
    task automatic bus_read(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        logic hit;
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        hit = model_write(a, d);
        @(negedge clk);
        bus_valid = 1'b0;
        check({tag, " R10 strobe after write"}, 64'(rescan), 64'(hit));
        check({tag, " R11 no rvalid after write"}, 64'(bus_rvalid), 64'h0);
        check_table({tag, " R7/R8 table"});
        @(negedge clk);
        check({tag, " R10 strobe one cycle"}, 64'(rescan), 64'h0);
    endtask

    // monitor: pops expected reads as results appear
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected rvalid", 64'(bus_rvalid), 64'h0);
            end else begin
                check(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        m_sel = 8'h00; m_id = 8'h00;
        for (int i = 0; i < N; i++) m_ent[i] = 64'h0000_0000_0001_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rescan low after reset", 64'(rescan), 64'h0);
        check_table("R1 masked entries");
        bus_read(12'h000, "R1 select reset");
        bus_read(12'h010, "R1 ident reset");

        // R2 select register
        bus_write(12'h000, 32'h0000_01AB, "R2 select write");
        bus_read(12'h000, "R2 select readback");

        // R4 identifier
        bus_write(12'h000, 32'h0, "R4 sel ident");
        bus_write(12'h010, 32'hDEAD_BEEF, "R4 ident write");
        bus_read(12'h010, "R4 ident readback");

        // R5 version
        bus_write(12'h000, 32'h1, "R5 sel version");
        bus_read(12'h010, "R5 version read");
        bus_write(12'h010, 32'hFFFF_FFFF, "R5 version write");
        bus_read(12'h010, "R5 version after write");

        // R6 reserved and unused low indexes
        bus_write(12'h000, 32'h2, "R6 sel reserved");
        bus_write(12'h010, 32'hFFFF_FFFF, "R6 reserved write");
        bus_read(12'h010, "R6 reserved read");
        bus_write(12'h000, 32'h5, "R6 sel 0x05");
        bus_write(12'h010, 32'hFFFF_FFFF, "R6 0x05 write");
        bus_read(12'h010, "R6 0x05 read");

        // R7/R8 entry halves
        bus_write(12'h000, 32'h10, "R7 sel e0 low");
        bus_write(12'h010, 32'h1234_5678, "R7 e0 low write");
        bus_read(12'h010, "R7 e0 low read");
        bus_write(12'h000, 32'h11, "R7 sel e0 high");
        bus_write(12'h010, 32'hA500_0000, "R8 e0 high write");
        bus_read(12'h010, "R7 e0 high read");
        bus_write(12'h000, 32'h10, "R8 sel e0 low again");
        bus_write(12'h010, 32'h0000_00FF, "R8 e0 low rewrite");
        bus_read(12'h000, "R2 select mid");
        bus_write(12'h000, 32'h2F, "R7 sel e15 high");
        bus_write(12'h010, 32'hCAFE_F00D, "R7 e15 high write");
        bus_read(12'h010, "R7 e15 high read");
        bus_write(12'h000, 32'h3E, "R7 sel e23 low");
        bus_write(12'h010, 32'h0000_0031, "R7 e23 low write");
        bus_read(12'h010, "R7 e23 low read");

        // R9 indexes past the table
        bus_write(12'h000, 32'h40, "R9 sel 0x40");
        bus_write(12'h010, 32'hFFFF_FFFF, "R9 0x40 write");
        bus_read(12'h010, "R9 0x40 read");
        bus_write(12'h000, 32'hFF, "R9 sel 0xFF");
        bus_write(12'h010, 32'hFFFF_FFFF, "R9 0xFF write");
        bus_read(12'h010, "R9 0xFF read");

        // R3 offset decode
        bus_write(12'h004, 32'hFFFF_FFFF, "R3 unused offset write");
        bus_read(12'h004, "R3 unused offset read");
        bus_read(12'h000, "R3 select untouched");
        bus_write(12'h300, 32'h12, "R3 alias select write");
        bus_write(12'hA10, 32'h7777_8888, "R3 alias window write");
        bus_read(12'h510, "R3 alias window read");

        // R11 back-to-back reads
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = 12'h000;
        exp_q.push_back(model_read(12'h000)); tag_q.push_back("R11 b2b read 1");
        @(negedge clk);
        bus_addr = 12'h010;
        exp_q.push_back(model_read(12'h010)); tag_q.push_back("R11 b2b read 2");
        @(negedge clk);
        bus_valid = 1'b0;
        @(negedge clk);
        check("R11 rvalid drops when idle", 64'(bus_rvalid), 64'h0);
        check("R11 scoreboard drained", 64'(exp_q.size()), 64'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule